// File: doc/BRIEF.md
# Dual-Register Serial Discrete Interface

This block is the logic side of an eight-channel discrete-input sensor. It receives eight discrete levels that are already digital. It exposes them to a host over a four-wire serial bus made of chip select, shift clock, serial in and serial out. It also holds one format bit per channel, which the host programs over the same bus.

The host picks the register for a frame with a select line. High picks the data register and low picks the configuration register. When chip select falls with the data register selected, the block captures the channel levels and shifts them out most significant bit first. In a configuration frame the host shifts in a new byte, and the byte is copied to the parallel format outputs when chip select rises.

All bus pins and channel levels are sampled by the block's own clock through two-flop synchronizers. Edges are detected in that clock domain. The bus must therefore run slower than the system clock, with each shift-clock level held for at least three system clocks.

Top module: `disc_serial_top`

## Requirements
- R1: After reset, `cfg_fmt` is all zeros and the captured register select is the data register.
- R2: `sdo_en` is high exactly while `cs_n` is low; `sdo` carries valid data only then.
- R3: On a falling edge of `cs_n` with `sel` high, the eight `din` levels are loaded into the data register, with channel k (`din[k]`) in register bit k. The first bit read, before any shift clock, is `din[7]`, followed by `din[6]` down to `din[0]`.
- R4: On each rising edge of `sclk` while `cs_n` is low, `sdi` enters bit 0 of the selected register and the other bits move one place toward bit 7. `sdo` shows bit 7 of the selected register, so bits written in one frame are read back eight clocks later, first-written first.
- R5: While `cs_n` is high, `sclk` and `sdi` activity changes neither register.
- R6: On a rising edge of `cs_n` with the configuration register selected, `cfg_fmt` takes the configuration shift register contents. `cfg_fmt` does not change at any other time, including during shifting. A `cfg_fmt[k]` of 1 selects 28 V/open sensing for channel k, and 0 selects ground/open sensing.
- R7: A rising edge of `cs_n` that ends a data-register frame leaves `cfg_fmt` unchanged.
- R8: `sel` is sampled only at the falling edge of `cs_n`. A change of `sel` during a frame does not change which register shifts, which register drives `sdo`, or whether a transfer happens at the end of the frame.
- R9: A change of `din` after the capture does not affect the bits read in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Digitized discrete channel levels |
| sel | input | 1 | Register select: 1 = data, 0 = configuration |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, bit 7 of the selected register |
| sdo_en | output | 1 | Output enable for the serial data out pad |
| cfg_fmt | output | 8 | Per-channel format select outputs |

## Verification
The assertions assume the bus is slow compared with `clk`. A shift-clock rise is never detected in the same system cycle as a chip-select fall, and `sdi` is stable across the synchronizer window around each rising shift-clock edge. The bench keeps to this. It holds every bus level for six system clocks and changes `sdi` only while `sclk` is low. It asserts chip select with `sclk` low, and it changes `din` and `sel` at least four clocks before a chip-select fall, or else deliberately in the middle of a frame.

// File: rtl/disc_serial_pkg.sv
package disc_serial_pkg;
  localparam int NCH = 8;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    SEL_CFG  = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/disc_sync.sv
module disc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= RST_VAL;
        else if (g == 0) stage[g] <= d;
        else stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/disc_edge.sv
module disc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sclk_s,
  output logic cs_fall,
  output logic cs_rise,
  output logic shift_en
);
  logic cs_d, sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_fall  = cs_d & ~cs_s;
  assign cs_rise  = ~cs_d & cs_s;
  // a shift counts only inside an open frame, never on the capture cycle
  assign shift_en = ~sclk_d & sclk_s & ~cs_s & ~cs_fall;
endmodule

// File: rtl/disc_shreg.sv
module disc_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (load) q <= load_val;
    else if (shift) q <= {q[W-2:0], ser_in};
  end
endmodule

// File: rtl/disc_serial_top.sv
module disc_serial_top
  import disc_serial_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  input  logic         sel,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         sdi,
  output logic         sdo,
  output logic         sdo_en,
  output logic [N-1:0] cfg_fmt
);
  localparam int BUS_W = 4;

  logic [N-1:0] din_s;
  logic [BUS_W-1:0] bus_s;
  logic cs_s, sclk_s, sdi_s, sel_s;
  logic cs_fall, cs_rise, shift_en;
  reg_sel_e sel_q;
  logic [N-1:0] data_q, cfg_q;

  disc_sync #(.W(N), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_din_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
  );

  // reset levels: chip select idle high, select defaults to data
  disc_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi, sel}), .q(bus_s)
  );
  assign {cs_s, sclk_s, sdi_s, sel_s} = bus_s;

  disc_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .shift_en(shift_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_DATA;
    else if (cs_fall) sel_q <= reg_sel_e'(sel_s);
  end

  disc_shreg #(.W(N)) u_data_sr (
    .clk(clk), .rst_n(rst_n),
    .load(cs_fall & sel_s), .load_val(din_s),
    .shift(shift_en & (sel_q == SEL_DATA)), .ser_in(sdi_s),
    .q(data_q)
  );

  disc_shreg #(.W(N)) u_cfg_sr (
    .clk(clk), .rst_n(rst_n),
    .load(1'b0), .load_val('0),
    .shift(shift_en & (sel_q == SEL_CFG)), .ser_in(sdi_s),
    .q(cfg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_fmt <= '0;
    else if (cs_rise && sel_q == SEL_CFG) cfg_fmt <= cfg_q;
  end

  assign sdo    = (sel_q == SEL_DATA) ? data_q[N-1] : cfg_q[N-1];
  assign sdo_en = ~cs_n;
endmodule

// File: rtl/disc_serial_chk.sv
module disc_serial_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_s,
  input logic         sel_s,
  input logic         sdi_s,
  input logic [N-1:0] din_s,
  input logic         cs_fall,
  input logic         cs_rise,
  input logic         shift_en,
  input logic         sel_q,
  input logic [N-1:0] data_q,
  input logic [N-1:0] cfg_q,
  input logic [N-1:0] cfg_fmt
);
  // R1: reset values visible while reset is held
  always_comb begin
    if (!rst_n) a_r1_reset_fmt: assert (cfg_fmt == '0);
  end

  // R3: capture on chip-select fall with data selected
  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall && sel_s |=> data_q == $past(din_s));

  // R4: a configuration shift brings the serial bit into bit 0
  a_r4_cfg_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && !sel_q |=> cfg_q[0] == $past(sdi_s) && cfg_q[N-1:1] == $past(cfg_q[N-2:0]));

  // R5: nothing moves while chip select is high
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(data_q) && $stable(cfg_q));

  // R6: the transfer copies the shift register
  a_r6_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && !sel_q |=> cfg_fmt == $past(cfg_q));

  // R6: outputs hold outside the end of a frame
  a_r6_fmt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(cfg_fmt));

  // R7: the end of a data frame does not touch the outputs
  a_r7_data_end: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && sel_q |=> $stable(cfg_fmt));

  // R8: the select is latched only at the start of a frame
  a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(sel_q));
endmodule

bind disc_serial_top disc_serial_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sel_s(sel_s), .sdi_s(sdi_s),
  .din_s(din_s), .cs_fall(cs_fall), .cs_rise(cs_rise), .shift_en(shift_en),
  .sel_q(sel_q), .data_q(data_q), .cfg_q(cfg_q), .cfg_fmt(cfg_fmt)
);

// File: tb/disc_serial_top_tb.sv
module disc_serial_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] din = 8'h00;
  logic sel = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  logic [7:0] cfg_fmt;

  int nchk = 0, nfail = 0;
  logic [7:0] m_cfg_sr = 8'h00, m_cfg_fmt = 8'h00;

  always #10 clk = ~clk;

  disc_serial_top u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .sel(sel), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en), .cfg_fmt(cfg_fmt)
  );

  // {sel, din, write byte}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 8'hA5, 8'h00},
    {1'b0, 8'h00, 8'h3C},
    {1'b1, 8'h81, 8'hFF},
    {1'b0, 8'hFF, 8'hC9},
    {1'b1, 8'h5A, 8'h12},
    {1'b0, 8'h0F, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mid: 0 none, 1 flip sel, 2 flip din, 3 check cfg_fmt holds
  task automatic xfer(input logic s, input logic [7:0] d, input logic [15:0] w,
                      input int nbits, input int mid, output logic [15:0] r);
    r = '0;
    sel = s; din = d;
    wait_clk(4);
    cs_n = 1'b0;
    wait_clk(2);
    chk("R2 sdo_en while selected", {15'b0, sdo_en}, 16'h1);
    wait_clk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = w[i];
      wait_clk(6);
      r[i] = sdo;
      sclk = 1'b1;
      wait_clk(6);
      sclk = 1'b0;
      if (i == nbits / 2) begin
        if (mid == 1) sel = ~sel;
        if (mid == 2) din = ~din;
        if (mid == 3) chk("R6 cfg_fmt steady mid-shift", {8'h0, cfg_fmt}, {8'h0, m_cfg_fmt});
      end
    end
    wait_clk(6);
    cs_n = 1'b1;
    wait_clk(6);
    chk("R2 sdo_en released", {15'b0, sdo_en}, 16'h0);
    sel = s;
  endtask

  logic [15:0] rd;

  initial begin
    wait_clk(3);
    chk("R1 cfg_fmt in reset", {8'h0, cfg_fmt}, 16'h0);
    chk("R2 sdo_en idle", {15'b0, sdo_en}, 16'h0);
    rst_n = 1'b1;
    wait_clk(3);
    chk("R1 cfg_fmt after reset", {8'h0, cfg_fmt}, 16'h0);

    // vector walk: R3 capture order, R4 shift, R6 transfer, R7 no transfer
    for (int v = 0; v < 6; v++) begin
      xfer(VEC[v][16], VEC[v][15:8], {8'h0, VEC[v][7:0]}, 8, 3, rd);
      if (VEC[v][16]) begin
        chk("R3 data read bit 7 first", rd, {8'h0, VEC[v][15:8]});
        chk("R7 cfg_fmt after data frame", {8'h0, cfg_fmt}, {8'h0, m_cfg_fmt});
      end else begin
        chk("R4 cfg readback of previous byte", rd, {8'h0, m_cfg_sr});
        m_cfg_sr = VEC[v][7:0];
        m_cfg_fmt = VEC[v][7:0];
        chk("R6 cfg_fmt after transfer", {8'h0, cfg_fmt}, {8'h0, m_cfg_fmt});
      end
    end

    // R4: 16-clock data frame returns the first written byte
    xfer(1'b1, 8'h6E, 16'hB4_00, 16, 0, rd);
    chk("R4 data pass-through", rd, 16'h6E_B4);

    // R5: shift clock toggling with chip select high is ignored
    xfer(1'b0, 8'h00, 16'h0096, 8, 0, rd);
    m_cfg_sr = 8'h96; m_cfg_fmt = 8'h96;
    for (int k = 0; k < 5; k++) begin
      sdi = k[0];
      wait_clk(6); sclk = 1'b1; wait_clk(6); sclk = 1'b0;
    end
    chk("R5 cfg_fmt with idle clocks", {8'h0, cfg_fmt}, 16'h0096);
    xfer(1'b0, 8'h00, 16'h0071, 8, 0, rd);
    chk("R5 cfg register held while idle", rd, 16'h0096);
    m_cfg_sr = 8'h71; m_cfg_fmt = 8'h71;

    // R8: select flipped mid-frame, configuration frame still transfers
    xfer(1'b0, 8'hFF, 16'h00E2, 8, 1, rd);
    chk("R8 cfg frame readback", rd, {8'h0, m_cfg_sr});
    chk("R8 transfer despite sel change", {8'h0, cfg_fmt}, 16'h00E2);
    m_cfg_sr = 8'hE2; m_cfg_fmt = 8'hE2;

    // R8: select flipped mid data frame, no transfer, data still read
    xfer(1'b1, 8'h3B, 16'h0055, 8, 1, rd);
    chk("R8 data frame readback", rd, 16'h003B);
    chk("R8 no transfer after data frame", {8'h0, cfg_fmt}, 16'h00E2);

    // R9: din changes after capture do not alter the read
    xfer(1'b1, 8'hC3, 16'h0000, 8, 2, rd);
    chk("R9 read unaffected by din change", rd, 16'h00C3);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule